// File: doc/BRIEF.md
# Interrupt routing register window

This block holds the programmable state of an I/O interrupt router and exposes it to software through two bus offsets: a select register that names an internal register, and a data window through which that register is read or written. The internal space holds a read-only version word, a 4-bit identification value (also readable as an arbitration word), and a routing table with one 64-bit entry per interrupt pin. Each entry is reached as two 32-bit halves, with the low half at an even select value and the high half at the following odd one.

The routing entries are exported in parallel to the service logic, which owns delivery. The service logic feeds back each pin's request level and can mark an entry as remote-pending. Whenever software rewrites any half of an entry, the block pulses that pin's rewrite strobe. If the pin's request is active at that moment, it also pulses a service strobe so that the pin is considered for delivery again. A low-half write always clears the entry's remote-pending flag.

The bus port is a request stream with valid/ready and a response stream without back-pressure. `req_ready` is low while reset is held and during the first clock after it, then stays high. A request is taken on any clock edge where both `req_valid` and `req_ready` are high. A write completes silently. A read returns its data one cycle later on `rsp_valid`/`rsp_rdata`, and the consumer must accept it in that cycle.

Top module: `irq_route_regs`

## Requirements
- R1: After reset every routing entry equals 0x0000_0000_0001_0000 (only the mask, bit 16, set), the select register and the identification value read zero, no strobe is active, and `req_ready` is low until the first clock edge after reset is released.
- R2: Bus offset 0x00 stores all 32 bits written to it and reads them back. Offset 0x10 is the data window. Reads of any other offset return zero, and writes to any other offset change nothing.
- R3: With select 0x01, the window reads the pin count minus one in bits 23:16 and the version code in bits 7:0, with all other bits zero. Window writes there change nothing.
- R4: With select 0x00, the window reads and writes the 4-bit identification value in bits 27:24. Select 0x02 reads the same value, and window writes at 0x02 change nothing.
- R5: For a select value s of 0x10 or more, the entry index is (s − 0x10) >> 1. An even s accesses entry bits 31:0 and an odd s accesses bits 63:32. Entry fields are: vector 7:0, delivery mode 10:8, destination mode 11, polarity 13, remote-pending 14, trigger mode 15, mask 16, destination 63:56.
- R6: A window access whose select is 0x03 to 0x0F, or whose computed index is at or beyond the pin count, reads zero and writes nothing.
- R7: A low-half write stores the data with bit 14 forced to zero, clearing remote-pending even when `rpend_set` for that pin is high in the same cycle. A high-half write leaves bits 31:0, including remote-pending, untouched.
- R8: `rpend_set[i]` high on a clock edge sets bit 14 of entry i unless a low-half write to entry i is taken on the same edge.
- R9: In the cycle after a table write to pin i is taken, `entry_wr[i]` is high for exactly one cycle and `svc_kick[i]` is high for that cycle exactly when `pin_req[i]` was high at the write. Both vectors are zero otherwise.
- R10: Writes with `req_size` (a byte count) other than 4 or 8 change no state and raise no strobe. Reads return the full word whatever their size.
- R11: Every accepted read produces exactly one response, in the next cycle, whose data reflects the state before the read's own edge. Writes produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request present |
| req_ready | output | 1 | Block accepts requests |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset within the block |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data present (one cycle) |
| rsp_rdata | output | 32 | Read data |
| pin_req | input | NPINS | Request level of each pin, from the service logic |
| rpend_set | input | NPINS | Set the remote-pending flag of an entry |
| entries_o | output | NPINS*64 | All routing entries; entry i occupies bits i*64+63 to i*64 |
| entry_wr | output | NPINS | Pin's entry was rewritten (one-cycle pulse) |
| svc_kick | output | NPINS | Rewritten pin had an active request (one-cycle pulse) |

## Verification
The most delicate case is a low-half write that lands on the same edge as a remote-pending set for the same pin. Here the clear must win, while a high-half write on another edge must leave the flag standing. The bench reaches it by driving `rpend_set` and the window write in the same cycle after first setting the flag alone. Select values that fall outside the table only through unsigned wrap-around (0x03 to 0x0F, 0xFFFFFFFF) and the first index past the last pin are also hard to reach by accident, so they are written and read on purpose. A bench-side model compares every output on every cycle.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  localparam int unsigned DATA_W  = 32;
  localparam int unsigned ENTRY_W = 64;

  // Bus offsets of the two visible registers.
  localparam logic [7:0] OFF_SELECT = 8'h00;
  localparam logic [7:0] OFF_WINDOW = 8'h10;

  // Select codes of the internal register space.
  localparam logic [31:0] SEL_ID       = 32'h0000_0000;
  localparam logic [31:0] SEL_VER      = 32'h0000_0001;
  localparam logic [31:0] SEL_ARB      = 32'h0000_0002;
  localparam logic [31:0] SEL_TBL_BASE = 32'h0000_0010;

  // Entry field positions that this block acts on.
  localparam int unsigned BIT_RPEND = 14;
  localparam int unsigned BIT_MASK  = 16;

  localparam logic [ENTRY_W-1:0] ENTRY_RESET = 64'h1 << BIT_MASK;

  typedef enum logic [2:0] {
    WT_ID,
    WT_VER,
    WT_ARB,
    WT_TBL,
    WT_NONE
  } win_tgt_e;

  function automatic logic size_ok(input logic [3:0] sz);
    return (sz == 4'd4) || (sz == 4'd8);
  endfunction

endpackage

// File: rtl/irq_route_decode.sv
module irq_route_decode
  import irq_route_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_ready,
  input  logic       req_write,
  input  logic [7:0] req_addr,
  input  logic [3:0] req_size,
  output logic       sel_wr_o,
  output logic       win_wr_o,
  output logic       rd_o
);

  logic take;
  logic wr_ok;

  assign take  = req_valid & req_ready;
  assign wr_ok = take & req_write & size_ok(req_size);

  assign sel_wr_o = wr_ok & (req_addr == OFF_SELECT);
  assign win_wr_o = wr_ok & (req_addr == OFF_WINDOW);
  assign rd_o     = take & ~req_write;

  // R10: narrow writes reach neither register
  p_narrow_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_size != 4'd4 && req_size != 4'd8)
      |-> (!sel_wr_o && !win_wr_o));

  // R11: a request is either a read or a write, never both
  p_rd_wr_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_o && (sel_wr_o || win_wr_o)));

endmodule

// File: rtl/irq_route_window.sv
module irq_route_window
  import irq_route_pkg::*;
#(
  parameter int unsigned NPINS = 24,
  parameter int unsigned IDX_W = 5
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_wr_i,
  input  logic             win_wr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      sel_o,
  output logic [3:0]       id_o,
  output win_tgt_e         tgt_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             hi_o,
  output logic [NPINS-1:0] tbl_wr_lo_o,
  output logic [NPINS-1:0] tbl_wr_hi_o
);

  logic [31:0] sel_q;
  logic [3:0]  id_q;
  logic [31:0] diff;
  logic [30:0] idx_full;
  logic        in_rng;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      id_q  <= '0;
    end else begin
      if (sel_wr_i) sel_q <= wdata_i;
      if (win_wr_i && tgt_o == WT_ID) id_q <= wdata_i[27:24];
    end
  end

  // Unsigned wrap makes selects below the table base land far out of range.
  assign diff     = sel_q - SEL_TBL_BASE;
  assign idx_full = diff[31:1];
  assign in_rng   = idx_full < 31'(NPINS);

  always_comb begin
    if (sel_q == SEL_ID)       tgt_o = WT_ID;
    else if (sel_q == SEL_VER) tgt_o = WT_VER;
    else if (sel_q == SEL_ARB) tgt_o = WT_ARB;
    else if (in_rng)           tgt_o = WT_TBL;
    else                       tgt_o = WT_NONE;
  end

  assign idx_o = idx_full[IDX_W-1:0];
  assign hi_o  = diff[0];
  assign sel_o = sel_q;
  assign id_o  = id_q;

  for (genvar p = 0; p < NPINS; p++) begin : g_strobe
    assign tbl_wr_lo_o[p] = win_wr_i && (tgt_o == WT_TBL) && (idx_o == IDX_W'(p)) && !hi_o;
    assign tbl_wr_hi_o[p] = win_wr_i && (tgt_o == WT_TBL) && (idx_o == IDX_W'(p)) &&  hi_o;
  end

  // R5: one half of one entry at most per write
  p_one_half_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tbl_wr_lo_o, tbl_wr_hi_o}));

  // R6: selects outside the register space and the table write nothing
  p_oob_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (win_wr_i && sel_q > SEL_ARB &&
     (sel_q < SEL_TBL_BASE || sel_q >= 32'(SEL_TBL_BASE + 2 * NPINS)))
      |-> ({tbl_wr_lo_o, tbl_wr_hi_o} == '0));

  // R4: identification only changes through a window write at select 0
  p_id_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(win_wr_i && sel_q == SEL_ID) |=> $stable(id_q));

endmodule

// File: rtl/irq_route_entry.sv
module irq_route_entry
  import irq_route_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_lo_i,
  input  logic               wr_hi_i,
  input  logic [31:0]        wdata_i,
  input  logic               rpend_set_i,
  input  logic               pin_req_i,
  output logic [ENTRY_W-1:0] entry_o,
  output logic               wr_pulse_o,
  output logic               kick_o
);

  logic [ENTRY_W-1:0] ent_q;
  logic               pulse_q;
  logic               kick_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_q   <= ENTRY_RESET;
      pulse_q <= 1'b0;
      kick_q  <= 1'b0;
    end else begin
      pulse_q <= wr_lo_i | wr_hi_i;
      kick_q  <= (wr_lo_i | wr_hi_i) & pin_req_i;
      if (rpend_set_i) ent_q[BIT_RPEND] <= 1'b1;
      // Later assignment wins: a low-half write clears remote-pending.
      if (wr_lo_i) ent_q[31:0] <= {wdata_i[31:BIT_RPEND+1], 1'b0, wdata_i[BIT_RPEND-1:0]};
      if (wr_hi_i) ent_q[63:32] <= wdata_i;
    end
  end

  assign entry_o    = ent_q;
  assign wr_pulse_o = pulse_q;
  assign kick_o     = kick_q;

  // R7: low-half write leaves remote-pending clear
  p_rpend_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo_i |=> !entry_o[BIT_RPEND]);

  // R7: high-half write keeps the low word
  p_hi_keeps_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi_i && !wr_lo_i && !rpend_set_i) |=> $stable(entry_o[31:0]));

  // R8: a set without a competing low write takes effect
  p_rpend_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rpend_set_i && !wr_lo_i) |=> entry_o[BIT_RPEND]);

  // R9: kick only accompanies a rewrite
  p_kick_with_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo_i || wr_hi_i) |=> (wr_pulse_o && (kick_o == $past(pin_req_i))));

endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int unsigned NPINS    = 24,
  parameter logic [7:0]  VER_CODE = 8'h11
)(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [7:0]               req_addr,
  input  logic [3:0]               req_size,
  input  logic [31:0]              req_wdata,
  output logic                     rsp_valid,
  output logic [31:0]              rsp_rdata,
  input  logic [NPINS-1:0]         pin_req,
  input  logic [NPINS-1:0]         rpend_set,
  output logic [NPINS*ENTRY_W-1:0] entries_o,
  output logic [NPINS-1:0]         entry_wr,
  output logic [NPINS-1:0]         svc_kick
);

  localparam int unsigned IDX_W = (NPINS > 1) ? $clog2(NPINS) : 1;
  localparam logic [7:0]  CNT8  = 8'(NPINS - 1);

  logic             ready_q;
  logic             sel_wr, win_wr, rd;
  logic [31:0]      sel_val;
  logic [3:0]       id_val;
  win_tgt_e         tgt;
  logic [IDX_W-1:0] tbl_idx;
  logic             tbl_hi;
  logic [NPINS-1:0] wr_lo, wr_hi;
  logic [ENTRY_W-1:0] ent_arr [NPINS];
  logic [31:0]      tbl_word, win_word, rd_word;
  logic             rsp_valid_q;
  logic [31:0]      rsp_rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end
  assign req_ready = ready_q;

  irq_route_decode u_decode (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (ready_q),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .sel_wr_o  (sel_wr),
    .win_wr_o  (win_wr),
    .rd_o      (rd)
  );

  irq_route_window #(.NPINS(NPINS), .IDX_W(IDX_W)) u_window (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel_wr_i    (sel_wr),
    .win_wr_i    (win_wr),
    .wdata_i     (req_wdata),
    .sel_o       (sel_val),
    .id_o        (id_val),
    .tgt_o       (tgt),
    .idx_o       (tbl_idx),
    .hi_o        (tbl_hi),
    .tbl_wr_lo_o (wr_lo),
    .tbl_wr_hi_o (wr_hi)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    irq_route_entry u_entry (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_lo_i     (wr_lo[p]),
      .wr_hi_i     (wr_hi[p]),
      .wdata_i     (req_wdata),
      .rpend_set_i (rpend_set[p]),
      .pin_req_i   (pin_req[p]),
      .entry_o     (ent_arr[p]),
      .wr_pulse_o  (entry_wr[p]),
      .kick_o      (svc_kick[p])
    );
    assign entries_o[p*ENTRY_W +: ENTRY_W] = ent_arr[p];
  end

  always_comb begin
    tbl_word = '0;
    for (int p = 0; p < NPINS; p++) begin
      if (tbl_idx == IDX_W'(p)) tbl_word = tbl_hi ? ent_arr[p][63:32] : ent_arr[p][31:0];
    end
  end

  always_comb begin
    unique case (tgt)
      WT_ID, WT_ARB: win_word = {4'h0, id_val, 24'h0};
      WT_VER:        win_word = {8'h00, CNT8, 8'h00, VER_CODE};
      WT_TBL:        win_word = tbl_word;
      default:       win_word = '0;
    endcase
  end

  always_comb begin
    if (req_addr == OFF_SELECT)      rd_word = sel_val;
    else if (req_addr == OFF_WINDOW) rd_word = win_word;
    else                             rd_word = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= rd;
      if (rd) rsp_rdata_q <= rd_word;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;

  // R11: every accepted read answers in the next cycle
  p_rsp_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid);

  // R11: no response without a read
  p_rsp_only_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready && !req_write) |=> !rsp_valid);

  // R9: at most one pin is rewritten per cycle
  p_wr_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(entry_wr));

  // R9: a kick only marks a rewritten pin
  p_kick_subset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((svc_kick & ~entry_wr) == '0));

endmodule

// File: tb/irq_route_regs_tb.sv
`timescale 1ns/1ps
module irq_route_regs_tb;

  localparam int NP = 24;
  localparam logic [7:0] VER = 8'h11;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0, req_write = 1'b0;
  logic            req_ready;
  logic [7:0]      req_addr = '0;
  logic [3:0]      req_size = 4'd4;
  logic [31:0]     req_wdata = '0;
  logic            rsp_valid;
  logic [31:0]     rsp_rdata;
  logic [NP-1:0]   pin_req = '0, rpend_set = '0;
  logic [NP*64-1:0] entries_o;
  logic [NP-1:0]   entry_wr, svc_kick;

  irq_route_regs #(.NPINS(NP), .VER_CODE(VER)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .pin_req(pin_req), .rpend_set(rpend_set), .entries_o(entries_o),
    .entry_wr(entry_wr), .svc_kick(svc_kick)
  );

  // Behavioural reference model
  logic [63:0]   m_ent [NP];
  logic [31:0]   m_sel, m_rd;
  logic [3:0]    m_id;
  logic          m_ready, m_rv, started = 1'b0;
  logic [NP-1:0] m_ewr, m_kick;
  logic          acc;
  longint        k;
  string         tag = "R1";
  int            n_chk = 0, n_bad = 0, cyc = 0;

  function automatic longint tbl_index(input logic [31:0] s);
    if (s < 32'h10) return -1;
    return longint'((s - 32'h10) >> 1);
  endfunction

  function automatic logic [31:0] m_window();
    longint ix;
    if (m_sel == 32'd0 || m_sel == 32'd2) return {4'h0, m_id, 24'h0};
    if (m_sel == 32'd1) return {8'h00, 8'(NP - 1), 8'h00, VER};
    ix = tbl_index(m_sel);
    if (ix >= 0 && ix < NP) return m_sel[0] ? m_ent[ix][63:32] : m_ent[ix][31:0];
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    started = 1'b1;
    if (!rst_n) begin
      for (int i = 0; i < NP; i++) m_ent[i] = 64'h1_0000;
      m_sel = '0; m_id = '0; m_ready = 1'b0; m_rv = 1'b0; m_rd = '0;
      m_ewr = '0; m_kick = '0;
    end else begin
      acc  = req_valid && m_ready;
      m_rv = acc && !req_write;
      if (m_rv) m_rd = (req_addr == 8'h00) ? m_sel : (req_addr == 8'h10) ? m_window() : 32'h0;
      for (int i = 0; i < NP; i++) if (rpend_set[i]) m_ent[i][14] = 1'b1;
      m_ewr = '0; m_kick = '0;
      if (acc && req_write && (req_size == 4'd4 || req_size == 4'd8)) begin
        if (req_addr == 8'h00) m_sel = req_wdata;
        else if (req_addr == 8'h10) begin
          k = tbl_index(m_sel);
          if (m_sel == 32'd0) m_id = req_wdata[27:24];
          else if (m_sel > 32'd2 && k >= 0 && k < NP) begin
            if (m_sel[0]) m_ent[k][63:32] = req_wdata;
            else begin
              m_ent[k][31:0] = req_wdata;
              m_ent[k][14]   = 1'b0;
            end
            m_ewr[k]  = 1'b1;
            m_kick[k] = pin_req[k];
          end
        end
      end
      m_ready = 1'b1;
    end
  end

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      chk("req_ready", 64'(req_ready), 64'(m_ready));
      chk("rsp_valid", 64'(rsp_valid), 64'(m_rv));
      if (m_rv) chk("rsp_rdata", 64'(rsp_rdata), 64'(m_rd));
      chk("entry_wr", 64'(entry_wr), 64'(m_ewr));
      chk("svc_kick", 64'(svc_kick), 64'(m_kick));
      for (int i = 0; i < NP; i++) chk($sformatf("entry%0d", i), entries_o[i*64 +: 64], m_ent[i]);
    end
  end

  task automatic bus(input logic wr, input logic [7:0] a, input logic [3:0] sz, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic wr32(input logic [7:0] a, input logic [31:0] d); bus(1'b1, a, 4'd4, d); endtask
  task automatic rd32(input logic [7:0] a); bus(1'b0, a, 4'd4, 32'h0); endtask
  task automatic pick(input logic [31:0] s); wr32(8'h00, s); endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual %0d expected below %0d", cyc, 20000);
      summary();
      $finish;
    end
  end

  initial begin
    tag = "R1";
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    pick(32'h0); rd32(8'h10);

    tag = "R2";
    pick(32'hDEAD_BEEF); rd32(8'h00);
    rd32(8'h20); rd32(8'h04); wr32(8'h20, 32'h1234_5678); rd32(8'h00);

    tag = "R3";
    pick(32'h1); rd32(8'h10); wr32(8'h10, 32'hFFFF_FFFF); rd32(8'h10);

    tag = "R4";
    pick(32'h0); wr32(8'h10, 32'hA5FF_FFFF); rd32(8'h10);
    pick(32'h2); rd32(8'h10); wr32(8'h10, 32'h0F00_0000); rd32(8'h10);
    pick(32'h0); rd32(8'h10);

    tag = "R5";
    foreach (m_ent[i]) begin end
    for (int p = 0; p < NP; p += 7) begin
      pick(32'h10 + 2 * p);     wr32(8'h10, 32'h0001_A000 | p);  rd32(8'h10);
      pick(32'h10 + 2 * p + 1); wr32(8'h10, 32'h5A00_0000 + p);  rd32(8'h10);
    end
    pick(32'h10 + 2 * (NP - 1)); wr32(8'h10, 32'h0000_0931); rd32(8'h10);

    tag = "R6";
    pick(32'h10 + 2 * NP); wr32(8'h10, 32'hFFFF_FFFF); rd32(8'h10);
    pick(32'h10 + 2 * NP + 1); wr32(8'h10, 32'hFFFF_FFFF); rd32(8'h10);
    pick(32'h5); wr32(8'h10, 32'hFFFF_FFFF); rd32(8'h10);
    pick(32'hF); wr32(8'h10, 32'hFFFF_FFFF); rd32(8'h10);
    pick(32'hFFFF_FFFF); wr32(8'h10, 32'hFFFF_FFFF); rd32(8'h10);

    tag = "R8";
    @(negedge clk); rpend_set[3] = 1'b1;
    @(negedge clk); rpend_set[3] = 1'b0;
    pick(32'h10 + 6); rd32(8'h10);

    tag = "R7";
    pick(32'h10 + 7); wr32(8'h10, 32'h1111_2222); pick(32'h10 + 6); rd32(8'h10);
    wr32(8'h10, 32'h0000_4040); rd32(8'h10);
    @(negedge clk); rpend_set[4] = 1'b1;
    @(negedge clk); rpend_set[4] = 1'b0;
    pick(32'h10 + 8);
    @(negedge clk);
    rpend_set[4] = 1'b1;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h10; req_size = 4'd4; req_wdata = 32'h0000_7F77;
    @(negedge clk);
    rpend_set[4] = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    rd32(8'h10);

    tag = "R9";
    pin_req[5] = 1'b1;
    pick(32'h10 + 10); wr32(8'h10, 32'h0000_8025);
    pick(32'h10 + 11); wr32(8'h10, 32'h0300_0000);
    pick(32'h10 + 12); wr32(8'h10, 32'h0000_0026);
    pin_req = '1;
    pick(32'h10 + 2 * NP); wr32(8'h10, 32'h0);
    pin_req = '0;

    tag = "R10";
    pick(32'h10 + 18);
    bus(1'b1, 8'h00, 4'd1, 32'h0000_0001);
    bus(1'b1, 8'h00, 4'd2, 32'h0000_0001);
    bus(1'b1, 8'h10, 4'd2, 32'h0000_00EE);
    bus(1'b1, 8'h10, 4'd0, 32'h0000_00EE);
    bus(1'b0, 8'h10, 4'd1, 32'h0);
    bus(1'b1, 8'h10, 4'd8, 32'h0000_00DD);
    rd32(8'h10);

    tag = "R11";
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_size = 4'd4; req_addr = 8'h00;
    @(negedge clk); req_addr = 8'h10;
    @(negedge clk); req_write = 1'b1; req_wdata = 32'h0000_0055;
    @(negedge clk); req_write = 1'b0;
    @(negedge clk); req_valid = 1'b0;
    repeat (2) @(negedge clk);

    tag = "R1";
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    rd32(8'h00); rd32(8'h10);

    repeat (2) @(negedge clk);
    summary();
    $finish;
  end

endmodule